// File: doc/BRIEF.md
# Streaming XOR Payload Cipher

This block sits in line on a 256-bit packet stream and scrambles the network-layer payload of each Ethernet frame by XORing it with a 32-bit key. The 14-byte link header and the 20-byte network header stay readable, so forwarding stages further down the stream can still parse the frame. XOR undoes itself. The same block therefore encrypts on one side of a link and decrypts on the other, provided both sides use the same key.

Each beat carries 32 bytes, and byte n sits on data bits [8n+7:8n]. Beats enter a small fall-through queue of four entries. The output always shows the beat at the head of that queue. A three-state position tracker records whether the head beat is the first beat of its frame, the second beat, or a later beat. The payload begins at frame byte 34, which is byte 2 of the second beat. For that reason the second beat is scrambled only from its byte 2 upward. The key is a static input. Eight copies of it are placed side by side across the bus, so frame byte 34 meets key byte 2.

Top module: `xor_payload_cipher`

## Requirements
- R1: The first beat of every frame (frame bytes 0 to 31) leaves with its data unchanged.
- R2: In the second beat of a frame, bytes 0 and 1 leave unchanged. Every byte n from 2 to 31 leaves XORed with key bits [8(n mod 4)+7 : 8(n mod 4)].
- R3: In every beat from the third onward, every byte n is XORed with key byte (n mod 4). Bytes that the strobe marks invalid are XORed as well.
- R4: The user sideband (128 bits, holding length in [15:0], source port in [23:16] and destination port in [31:24]), the 32-bit byte strobe and the last flag leave unchanged alongside their beat.
- R5: A beat with the last flag set returns the tracker to the first-beat position. A one-beat frame is never scrambled, and the next frame starts with a clear first beat.
- R6: The queue holds at most 4 beats. The input ready signal is high exactly when fewer than 4 beats are held. The output valid signal is high exactly when at least one beat is held. A beat that arrives at an empty queue is visible on the output in the next cycle.
- R7: Beats leave in arrival order with none lost or repeated. A beat leaves only in a cycle where output valid and output ready are both high. While valid is high and ready is low, the output stays stable.
- R8: With a key of zero, every output beat equals its input beat.
- R9: Passing a frame through the block twice with the same key returns the original frame.
- R10: After reset the output valid signal is low and the input ready signal is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_i | input | 32 | Static cipher key; change it only when the block is empty |
| s_tdata | input | 256 | Input beat data |
| s_tstrb | input | 32 | Input byte strobe |
| s_tuser | input | 128 | Input sideband |
| s_tlast | input | 1 | Input last beat of frame |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can accept a beat |
| m_tdata | output | 256 | Output beat data |
| m_tstrb | output | 32 | Output byte strobe |
| m_tuser | output | 128 | Output sideband |
| m_tlast | output | 1 | Output last beat of frame |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts the beat |

## Verification
Frames of one, two, three and five beats run with the sink always ready. Together they separate the clear first beat, the partially scrambled second beat and the fully scrambled later beats. They also show that a one-beat frame resets the position. A run with random valid and heavy backpressure fills the queue, which exposes ordering, stall stability and the full threshold. A zero key separates masking errors from passthrough errors. Finally, frames are scrambled, captured and sent back through the block, and the second pass must return the original frames, which catches any lane misalignment of the key.

// File: rtl/cipher_pkg.sv
// Shared types for the XOR payload cipher.
// Assumes: nothing beyond IEEE 1800-2017.
package cipher_pkg;

    // Position of the head beat inside its frame
    typedef enum logic [1:0] {
        SEG_HEAD  = 2'd0,   // first beat, all header
        SEG_SPLIT = 2'd1,   // beat where header ends and payload begins
        SEG_BODY  = 2'd2    // payload only
    } seg_e;

endpackage

// File: rtl/cipher_fifo.sv
// Fall-through queue: the head entry is shown combinationally on the output.
// Assumes: DEPTH >= 2; out_data is only meaningful while out_valid is high.
module cipher_fifo #(
    parameter int W     = 417,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push, pop;

    assign in_ready  = (count != CW'(DEPTH));
    assign out_valid = (count != '0);
    assign push      = in_valid && in_ready;
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_ptr];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Store an accepted beat at the write pointer
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= in_data;
    end

    // Advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    // R6
    full_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(push && !pop));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/cipher_pos_tracker.sv
// Tracks where the head beat sits in its frame: first, split or body beat.
// Assumes: advances only on beats actually handed downstream.
module cipher_pos_tracker
    import cipher_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beat_done,
    input  logic beat_last,
    output seg_e seg
);
    // Move to the next segment on each delivered beat, restart after last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg <= SEG_HEAD;
        end else if (beat_done) begin
            if (beat_last)           seg <= SEG_HEAD;
            else if (seg == SEG_HEAD) seg <= SEG_SPLIT;
            else                     seg <= SEG_BODY;
        end
    end

    // R5
    last_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && beat_last) |=> (seg == SEG_HEAD));

    // R2
    split_follows_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !beat_last && seg == SEG_HEAD) |=> (seg == SEG_SPLIT));

    // R3
    body_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && !beat_last && seg != SEG_HEAD) |=> (seg == SEG_BODY));

endmodule

// File: rtl/cipher_mask_gen.sv
// Builds the XOR mask for one beat from the key and the beat's segment.
// Assumes: the header ends inside the second beat (WORD_BYTES <= HDR_BYTES < 2*WORD_BYTES).
module cipher_mask_gen
    import cipher_pkg::*;
#(
    parameter int DATA_W    = 256,
    parameter int KEY_W     = 32,
    parameter int HDR_BYTES = 34
) (
    input  seg_e              seg,
    input  logic [KEY_W-1:0]  key,
    output logic [DATA_W-1:0] mask
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int KEY_BYTES  = KEY_W / 8;
    localparam int SPLIT_LANE = HDR_BYTES - WORD_BYTES;

    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        localparam int KLANE      = l % KEY_BYTES;
        localparam bit IN_PAYLOAD = (l >= SPLIT_LANE);
        logic en;
        // Lane is payload in body beats, and in the split beat past the header
        always_comb en = (seg == SEG_BODY) || (seg == SEG_SPLIT && IN_PAYLOAD);
        assign mask[8*l +: 8] = en ? key[8*KLANE +: 8] : 8'h00;
    end

endmodule

// File: rtl/xor_payload_cipher.sv
// In-line payload scrambler: XORs every byte past the link and network headers
// with a replicated key; sideband, strobe and last pass untouched.
// Assumes: no network-header options; key_i stays constant while beats are held.
module xor_payload_cipher
    import cipher_pkg::*;
#(
    parameter int DATA_W     = 256,
    parameter int USER_W     = 128,
    parameter int KEY_W      = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int HDR_BYTES  = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KEY_W-1:0]  key_i,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic [DATA_W/8-1:0] s_tstrb,
    input  logic [USER_W-1:0] s_tuser,
    input  logic              s_tlast,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic [DATA_W/8-1:0] m_tstrb,
    output logic [USER_W-1:0] m_tuser,
    output logic              m_tlast,
    output logic              m_tvalid,
    input  logic              m_tready
);
    localparam int STRB_W = DATA_W / 8;
    localparam int BEAT_W = DATA_W + STRB_W + USER_W + 1;

    logic [BEAT_W-1:0] in_beat, head_beat;
    logic [DATA_W-1:0] head_data, mask;
    seg_e              seg;
    logic              beat_done;

    assign in_beat = {s_tdata, s_tstrb, s_tuser, s_tlast};

    cipher_fifo #(.W(BEAT_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_beat),
        .in_valid  (s_tvalid),
        .in_ready  (s_tready),
        .out_data  (head_beat),
        .out_valid (m_tvalid),
        .out_ready (m_tready)
    );

    assign {head_data, m_tstrb, m_tuser, m_tlast} = head_beat;
    assign beat_done = m_tvalid && m_tready;

    cipher_pos_tracker i_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_done (beat_done),
        .beat_last (m_tlast),
        .seg       (seg)
    );

    cipher_mask_gen #(.DATA_W(DATA_W), .KEY_W(KEY_W), .HDR_BYTES(HDR_BYTES)) i_mask (
        .seg  (seg),
        .key  (key_i),
        .mask (mask)
    );

    assign m_tdata = head_data ^ mask;

    // R1
    head_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && seg == SEG_HEAD) |-> (m_tdata == head_data));

    // R8
    key_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && key_i == '0) |-> (m_tdata == head_data));

endmodule

// File: tb/test_xor_payload_cipher.sv
module test_xor_payload_cipher;
    localparam int DW = 256, SW = 32, UW = 128;

    typedef struct {
        logic [DW-1:0] d;
        logic [SW-1:0] s;
        logic [UW-1:0] u;
        logic          l;
        int            idx;
    } beat_t;

    logic clk = 0, rst_n = 0;
    logic [31:0] key_i = '0;
    logic [DW-1:0] s_tdata = '0;
    logic [SW-1:0] s_tstrb = '0;
    logic [UW-1:0] s_tuser = '0;
    logic s_tlast = 0, s_tvalid = 0, m_tready = 0;
    wire  s_tready, m_tlast, m_tvalid;
    wire [DW-1:0] m_tdata;
    wire [SW-1:0] m_tstrb;
    wire [UW-1:0] m_tuser;

    always #4 clk = ~clk;

    xor_payload_cipher i_xor_payload_cipher (
        .clk(clk), .rst_n(rst_n), .key_i(key_i),
        .s_tdata(s_tdata), .s_tstrb(s_tstrb), .s_tuser(s_tuser), .s_tlast(s_tlast),
        .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tuser(m_tuser), .m_tlast(m_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready)
    );

    int vectors = 0, fails = 0;
    beat_t src[$], mq[$], cap[$], orig[$];
    int in_idx = 0;
    int valid_pct = 100, ready_pct = 100;
    bit pend_push = 0, pend_pop = 0, running = 0, saw_full = 0;
    beat_t pend_item;

    // Behavioural expectation: frame byte f >= 34 is XORed with key byte f mod 4
    function automatic logic [DW-1:0] expect_data(logic [DW-1:0] d, int idx, logic [31:0] k);
        logic [DW-1:0] r = d;
        for (int b = 0; b < 32; b++) begin
            int f = idx * 32 + b;
            if (f >= 34) r[8*b +: 8] = r[8*b +: 8] ^ k[8*(f % 4) +: 8];
        end
        return r;
    endfunction

    function automatic string data_tag(int idx);
        if (key_i == '0) return "R8";
        if (idx == 0) return "R1";
        if (idx == 1) return "R2";
        return "R3";
    endfunction

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle model update, comparison and stimulus
    always @(negedge clk) begin
        if (running) begin
            if (pend_pop) begin
                cap.push_back('{m_tdata_q, m_tstrb_q, m_tuser_q, m_tlast_q, 0});
                void'(mq.pop_front());
            end
            if (pend_push) begin
                mq.push_back(pend_item);
                void'(src.pop_front());
            end
            if (mq.size() == 4) saw_full = 1;
            chk(s_tready == (mq.size() < 4), "R6", "in_ready", DW'(s_tready), DW'(mq.size() < 4));
            chk(m_tvalid == (mq.size() > 0), "R6", "out_valid", DW'(m_tvalid), DW'(mq.size() > 0));
            if (m_tvalid && mq.size() > 0) begin
                chk(m_tdata == mq[0].d, data_tag(mq[0].idx), "data", m_tdata, mq[0].d);
                chk(m_tstrb == mq[0].s, "R4", "strb", DW'(m_tstrb), DW'(mq[0].s));
                chk(m_tuser == mq[0].u, "R4", "user", DW'(m_tuser), DW'(mq[0].u));
                chk(m_tlast == mq[0].l, "R5", "last", DW'(m_tlast), DW'(mq[0].l));
            end
            m_tdata_q = m_tdata; m_tstrb_q = m_tstrb; m_tuser_q = m_tuser; m_tlast_q = m_tlast;
            s_tvalid = (src.size() > 0) && ($urandom_range(99) < valid_pct);
            if (src.size() > 0) begin
                s_tdata = src[0].d; s_tstrb = src[0].s; s_tuser = src[0].u; s_tlast = src[0].l;
            end
            m_tready = ($urandom_range(99) < ready_pct);
            pend_push = s_tvalid && (mq.size() < 4);
            pend_pop  = (mq.size() > 0) && m_tready;
            if (pend_push) begin
                pend_item = '{expect_data(src[0].d, in_idx, key_i), src[0].s, src[0].u, src[0].l, in_idx};
                in_idx = src[0].l ? 0 : in_idx + 1;
            end
        end
    end

    logic [DW-1:0] m_tdata_q;
    logic [SW-1:0] m_tstrb_q;
    logic [UW-1:0] m_tuser_q;
    logic          m_tlast_q;

    task automatic add_frame(int n, logic [UW-1:0] u);
        for (int i = 0; i < n; i++) begin
            beat_t b;
            for (int w = 0; w < 8; w++) b.d[32*w +: 32] = $urandom;
            b.s = (i == n - 1) ? 32'h0000_0FFF : '1;
            b.u = u;
            b.l = (i == n - 1);
            b.idx = i;
            src.push_back(b);
        end
    endtask

    task automatic drain();
        do @(posedge clk); while (src.size() != 0 || mq.size() != 0 || pend_push || pend_pop);
        @(posedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(m_tvalid == 1'b0, "R10", "valid after reset", DW'(m_tvalid), 0);
        chk(s_tready == 1'b1, "R10", "ready after reset", DW'(s_tready), 1);
        running = 1;

        // R1 R2 R3 R5: frame lengths 1,2,3,5, sink always ready
        key_i = 32'hA5C3_1E77;
        add_frame(1, 128'h0203_0040);
        add_frame(2, 128'h0401_0080);
        add_frame(3, 128'h0102_00A0);
        add_frame(1, 128'h0804_0020);
        add_frame(5, 128'h0108_0120);
        drain();

        // R6 R7: backpressure fills the queue
        valid_pct = 80; ready_pct = 25;
        for (int i = 0; i < 12; i++) add_frame(1 + (i % 5), UW'(i));
        drain();
        vectors++;
        if (!saw_full) begin
            fails++;
            $display("FAIL R6 queue never filled actual=0 expected=1");
        end

        // R8: zero key leaves beats untouched
        valid_pct = 100; ready_pct = 70;
        key_i = '0;
        for (int i = 0; i < 4; i++) add_frame(2 + i, UW'(100 + i));
        drain();

        // R9: scramble then descramble with the same key
        key_i = 32'h3C96_0F1B;
        ready_pct = 100;
        cap.delete();
        add_frame(4, 128'hAA);
        add_frame(2, 128'hBB);
        orig = src;
        drain();
        src = cap;
        cap.delete();
        valid_pct = 60; ready_pct = 60;
        drain();
        vectors++;
        if (cap.size() != orig.size()) begin
            fails++;
            $display("FAIL R9 beat count actual=%0d expected=%0d", cap.size(), orig.size());
        end else begin
            foreach (orig[i]) chk(cap[i].d == orig[i].d, "R9", "round trip", cap[i].d, orig[i].d);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule